// File: doc/BRIEF.md
# Scaler Output Size Calculator

This block works out the picture size a display scaler must produce for one head. It is given the size of the mode being shown (the source), the size of the attached panel (the native mode), a scaling policy, underscan controls with optional border widths, and the interlace and double-scan flags. It returns the width and height packed in one 32-bit word, plus a flag that tells whether the scaler has to be engaged at all.

A one-cycle `start_i` pulse latches every input and starts the computation. Underscan shrink is applied first. Center clamping or aspect-preserving fitting follows. The aspect ratios are Q19 fixed-point quotients from a shared restoring divider. A one-cycle `done_o` pulse marks the moment the packed size and the flag take their new values. The outputs then hold until the next result.

The control is a state machine with these states:
- `ST_IDLE`: waits for start and latches the inputs.
- `ST_U_DIV`: launches the underscan ratio division.
- `ST_U_WAIT`: waits for that quotient.
- `ST_U_SHRINK`: reduces the width.
- `ST_U_HEIGHT`: reduces or rederives the height.
- `ST_FIT`: applies the center clamp or picks the aspect direction.
- `ST_A_DIV`: launches the source ratio division.
- `ST_A_WAIT`: waits for that quotient.
- `ST_A_APPLY`: derives the free dimension.
- `ST_FINISH`: publishes the result.

The transitions are:
- `ST_IDLE`→`ST_U_DIV` on start with underscan active.
- `ST_IDLE`→`ST_FIT` on start without underscan.
- `ST_U_DIV`→`ST_U_WAIT`.
- `ST_U_WAIT`→`ST_U_SHRINK` on divider done.
- `ST_U_SHRINK`→`ST_U_HEIGHT`.
- `ST_U_HEIGHT`→`ST_FIT`.
- `ST_FIT`→`ST_A_DIV` in aspect mode, otherwise `ST_FIT`→`ST_FINISH`.
- `ST_A_DIV`→`ST_A_WAIT`.
- `ST_A_WAIT`→`ST_A_APPLY` on divider done.
- `ST_A_APPLY`→`ST_FINISH`.
- `ST_FINISH`→`ST_IDLE`.

Top module: `scaler_size_calc`

## Requirements
- R1: The starting size is the source size when `scale_mode_i` is 0 (none). For 1 (full), 2 (center) and 3 (aspect) the starting size is the native size.
- R2: The double-scan flag of the chosen starting mode doubles the starting height. This is `src_dbl_i` for mode 0 and `nat_dbl_i` otherwise.
- R3: Underscan is applied when `us_mode_i` is 1. It is also applied when `us_mode_i` is 2 and `sink_hdmi_i` is high. The values 0 and 3 never apply it.
- R4: Under underscan, a nonzero `us_hborder_i` reduces the width by twice its value. A zero border reduces the width W by (W>>4)+32.
- R5: Under underscan, a nonzero `us_vborder_i` reduces the height by twice its value. A zero border sets the height to (W'·A + A/2)>>19, where A = (H<<19)/W is taken from the height and width before the width shrink, and W' is the shrunk width.
- R6: Center mode clamps the width to min(source width, width) and the height to min(source height, height).
- R7: Aspect mode compares source width × height with source height × width. If the first is greater or equal, the width is kept and the height becomes (W·Q + Q/2)>>19 with Q = (src_h<<19)/src_w. Otherwise the height is kept and the width becomes (H·Q + Q/2)>>19 with Q = (src_w<<19)/src_h.
- R8: Full and none modes apply no fitting after the underscan step.
- R9: `active_o` is high when the result differs from the source size in either dimension, or when the source is interlaced or double-scanned.
- R10: `out_size_o` carries the height in bits 31:16 and the width in bits 15:0.
- R11: `done_o` is a one-cycle pulse that is visible 2 clock edges after the start-sampling edge. Underscan adds 39 edges and aspect mode adds 38 edges.
- R12: Inputs are sampled only by the start-sampling edge. A start pulse during a computation is ignored. `out_size_o` and `active_o` change only together with `done_o`.
- R13: After reset, `done_o`, `out_size_o` and `active_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; samples all inputs |
| src_w_i | input | 16 | Source mode width |
| src_h_i | input | 16 | Source mode height |
| src_ilace_i | input | 1 | Source mode is interlaced |
| src_dbl_i | input | 1 | Source mode is double-scanned |
| nat_w_i | input | 16 | Native panel width |
| nat_h_i | input | 16 | Native panel height |
| nat_dbl_i | input | 1 | Native mode is double-scanned |
| scale_mode_i | input | 2 | 0 none, 1 full, 2 center, 3 aspect |
| us_mode_i | input | 2 | 0 off, 1 on, 2 auto, 3 off |
| sink_hdmi_i | input | 1 | Sink reported as HDMI (used by auto) |
| us_hborder_i | input | 8 | Horizontal underscan border, 0 = derived |
| us_vborder_i | input | 8 | Vertical underscan border, 0 = derived |
| done_o | output | 1 | Result-ready pulse |
| out_size_o | output | 32 | Packed output height and width |
| active_o | output | 1 | Scaler must be engaged |

## Verification
The result is due on a fixed edge that depends only on which stages run. The base path takes 2 edges after the start-sampling edge. The underscan stage adds 39 edges and the aspect stage adds 38. The bench predicts that edge for every job from the same stage selection. It then compares `done_o` after every following edge, and compares the packed size and flag on the predicted edge. On every earlier cycle it checks that the previous result is still held. Extra start pulses are injected mid-job, with a changed source width, to show that they neither move the due edge nor alter the result.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        SCL_NONE   = 2'd0,
        SCL_FULL   = 2'd1,
        SCL_CENTER = 2'd2,
        SCL_ASPECT = 2'd3
    } scale_mode_e;

    typedef enum logic [1:0] {
        USC_OFF  = 2'd0,
        USC_ON   = 2'd1,
        USC_AUTO = 2'd2,
        USC_RSVD = 2'd3
    } usc_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_U_DIV,
        ST_U_WAIT,
        ST_U_SHRINK,
        ST_U_HEIGHT,
        ST_FIT,
        ST_A_DIV,
        ST_A_WAIT,
        ST_A_APPLY,
        ST_FINISH
    } calc_state_e;

endpackage

// File: rtl/ssc_divider.sv
module ssc_divider #(
    parameter int NUM_W = 35,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o,
    output logic [DEN_W-1:0] rem_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    logic [DEN_W:0]   rem_sh;
    logic [DEN_W:0]   rem_sub;
    logic             take;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    assign rem_sh  = {rem_q, quo_q[NUM_W-1]};
    assign rem_sub = rem_sh - {1'b0, den_q};
    assign take    = rem_sh >= {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q  <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                quo_q  <= num_i;
                rem_q  <= '0;
                den_q  <= den_i;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                quo_q <= {quo_q[NUM_W-2:0], take};
                rem_q <= take ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign quo_o  = quo_q;
    assign rem_o  = rem_q;

    // Remainder of a finished nonzero division is below the divisor (ratio of R5/R7).
    assert_div_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && den_q != '0) |-> (rem_q < den_q));

    // A finished division never coincides with a busy divider.
    assert_div_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

endmodule

// File: rtl/ssc_qmul.sv
module ssc_qmul #(
    parameter int DIM_W = 16,
    parameter int Q_W   = 35,
    parameter int FRAC  = 19
) (
    input  logic [DIM_W-1:0] len_i,
    input  logic [Q_W-1:0]   ratio_i,
    output logic [DIM_W-1:0] len_o
);
    localparam int PROD_W = DIM_W + Q_W + 1;

    logic [PROD_W-1:0] prod;

    // Scale a length by a Q-format ratio, rounding half up, keep DIM_W bits.
    always_comb begin
        prod  = PROD_W'(len_i) * PROD_W'(ratio_i) + PROD_W'(ratio_i >> 1);
        len_o = prod[FRAC +: DIM_W];
    end

endmodule

// File: rtl/scaler_size_calc.sv
module scaler_size_calc
    import ssc_pkg::*;
#(
    parameter int DIM_W    = 16,
    parameter int FRAC     = 19,
    parameter int BORDER_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DIM_W-1:0]     src_w_i,
    input  logic [DIM_W-1:0]     src_h_i,
    input  logic                 src_ilace_i,
    input  logic                 src_dbl_i,
    input  logic [DIM_W-1:0]     nat_w_i,
    input  logic [DIM_W-1:0]     nat_h_i,
    input  logic                 nat_dbl_i,
    input  logic [1:0]           scale_mode_i,
    input  logic [1:0]           us_mode_i,
    input  logic                 sink_hdmi_i,
    input  logic [BORDER_W-1:0]  us_hborder_i,
    input  logic [BORDER_W-1:0]  us_vborder_i,
    output logic                 done_o,
    output logic [2*DIM_W-1:0]   out_size_o,
    output logic                 active_o
);
    localparam int Q_W    = DIM_W + FRAC;
    localparam int PROD_W = 2 * DIM_W;
    localparam logic [DIM_W-1:0] US_PAD = DIM_W'(32);

    calc_state_e state_q, state_d;

    // Job registers, captured on the start-sampling edge.
    logic [DIM_W-1:0]    src_w_q, src_h_q;
    logic                ilace_q, sdbl_q;
    scale_mode_e         mode_q;
    logic [BORDER_W-1:0] hb_q, vb_q;

    // Working size and ratio.
    logic [DIM_W-1:0]    ox_q, oy_q;
    logic [Q_W-1:0]      ratio_q;
    logic [Q_W-1:0]      div_num_q;
    logic [DIM_W-1:0]    div_den_q;
    logic                keep_w_q;

    logic [2*DIM_W-1:0]  size_q;
    logic                active_q, done_q;

    // Start-size selection from the raw inputs.
    scale_mode_e         mode_in;
    logic [DIM_W-1:0]    start_w, start_h, start_h_eff;
    logic                start_dbl, us_apply;

    always_comb begin
        mode_in     = scale_mode_e'(scale_mode_i);
        start_w     = (mode_in == SCL_NONE) ? src_w_i   : nat_w_i;
        start_h     = (mode_in == SCL_NONE) ? src_h_i   : nat_h_i;
        start_dbl   = (mode_in == SCL_NONE) ? src_dbl_i : nat_dbl_i;
        start_h_eff = start_dbl ? (start_h << 1) : start_h;
        us_apply    = (usc_mode_e'(us_mode_i) == USC_ON) ||
                      ((usc_mode_e'(us_mode_i) == USC_AUTO) && sink_hdmi_i);
    end

    // Shared divider.
    logic               div_start, div_busy, div_done;
    logic [Q_W-1:0]     div_quo;
    logic [DIM_W-1:0]   div_rem;

    assign div_start = (state_q == ST_U_DIV) || (state_q == ST_A_DIV);

    ssc_divider #(.NUM_W(Q_W), .DEN_W(DIM_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_start),
        .num_i  (div_num_q),
        .den_i  (div_den_q),
        .busy_o (div_busy),
        .done_o (div_done),
        .quo_o  (div_quo),
        .rem_o  (div_rem)
    );

    // Shared rounding multiplier.
    logic [DIM_W-1:0] qmul_len, qmul_res;

    assign qmul_len = (state_q == ST_A_APPLY && !keep_w_q) ? oy_q : ox_q;

    ssc_qmul #(.DIM_W(DIM_W), .Q_W(Q_W), .FRAC(FRAC)) u_qmul (
        .len_i  (qmul_len),
        .ratio_i(ratio_q),
        .len_o  (qmul_res)
    );

    // Source at least as wide as the current output rectangle.
    logic src_wider;
    assign src_wider = (PROD_W'(src_w_q) * PROD_W'(oy_q)) >=
                       (PROD_W'(src_h_q) * PROD_W'(ox_q));

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = us_apply ? ST_U_DIV : ST_FIT;
            ST_U_DIV:    state_d = ST_U_WAIT;
            ST_U_WAIT:   if (div_done) state_d = ST_U_SHRINK;
            ST_U_SHRINK: state_d = ST_U_HEIGHT;
            ST_U_HEIGHT: state_d = ST_FIT;
            ST_FIT:      state_d = (mode_q == SCL_ASPECT) ? ST_A_DIV : ST_FINISH;
            ST_A_DIV:    state_d = ST_A_WAIT;
            ST_A_WAIT:   if (div_done) state_d = ST_A_APPLY;
            ST_A_APPLY:  state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_w_q   <= '0;
            src_h_q   <= '0;
            ilace_q   <= 1'b0;
            sdbl_q    <= 1'b0;
            mode_q    <= SCL_NONE;
            hb_q      <= '0;
            vb_q      <= '0;
            ox_q      <= '0;
            oy_q      <= '0;
            ratio_q   <= '0;
            div_num_q <= '0;
            div_den_q <= '0;
            keep_w_q  <= 1'b0;
            size_q    <= '0;
            active_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    src_w_q   <= src_w_i;
                    src_h_q   <= src_h_i;
                    ilace_q   <= src_ilace_i;
                    sdbl_q    <= src_dbl_i;
                    mode_q    <= mode_in;
                    hb_q      <= us_hborder_i;
                    vb_q      <= us_vborder_i;
                    ox_q      <= start_w;
                    oy_q      <= start_h_eff;
                    div_num_q <= {start_h_eff, {FRAC{1'b0}}};
                    div_den_q <= start_w;
                end
                ST_U_WAIT:  if (div_done) ratio_q <= div_quo;
                ST_U_SHRINK: begin
                    if (hb_q != '0) ox_q <= ox_q - DIM_W'({hb_q, 1'b0});
                    else            ox_q <= ox_q - (ox_q >> 4) - US_PAD;
                end
                ST_U_HEIGHT: begin
                    if (vb_q != '0) oy_q <= oy_q - DIM_W'({vb_q, 1'b0});
                    else            oy_q <= qmul_res;
                end
                ST_FIT: begin
                    if (mode_q == SCL_CENTER) begin
                        ox_q <= (src_w_q < ox_q) ? src_w_q : ox_q;
                        oy_q <= (src_h_q < oy_q) ? src_h_q : oy_q;
                    end else if (mode_q == SCL_ASPECT) begin
                        keep_w_q <= src_wider;
                        if (src_wider) begin
                            div_num_q <= {src_h_q, {FRAC{1'b0}}};
                            div_den_q <= src_w_q;
                        end else begin
                            div_num_q <= {src_w_q, {FRAC{1'b0}}};
                            div_den_q <= src_h_q;
                        end
                    end
                end
                ST_A_WAIT:  if (div_done) ratio_q <= div_quo;
                ST_A_APPLY: begin
                    if (keep_w_q) oy_q <= qmul_res;
                    else          ox_q <= qmul_res;
                end
                ST_FINISH: begin
                    size_q   <= {oy_q, ox_q};
                    active_q <= (ox_q != src_w_q) || (oy_q != src_h_q) ||
                                ilace_q || sdbl_q;
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign done_o     = done_q;
    assign out_size_o = size_q;
    assign active_o   = active_q;

    // Quotient and remainder reconstruct the latched dividend (ratios of R5 and R7).
    assert_ratio_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done && div_den_q != '0) |->
        ((64'(div_quo) * 64'(div_den_q) + 64'(div_rem)) == 64'(div_num_q)));

    // Center clamp never leaves a dimension above the source.
    assert_center_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && mode_q == SCL_CENTER) |->
        (ox_q <= src_w_q && oy_q <= src_h_q));

    // A size differing from the source raises the active flag.
    assert_active_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && out_size_o != {src_h_q, src_w_q}) |-> active_o);

    // Result is a single-cycle pulse.
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Published values move only with the result pulse.
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(out_size_o) || !$stable(active_o)) |-> done_o);

    // A start while a job runs leaves the divider schedule intact.
    assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_U_WAIT && div_busy) |=> (state_q == ST_U_WAIT));

endmodule

// File: tb/scaler_size_calc_bench.sv
module scaler_size_calc_bench;
    localparam int DIM_W = 16;
    localparam int FRAC  = 19;
    localparam int QW    = DIM_W + FRAC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] src_w_i = '0, src_h_i = '0, nat_w_i = '0, nat_h_i = '0;
    logic        src_ilace_i = 1'b0, src_dbl_i = 1'b0, nat_dbl_i = 1'b0;
    logic [1:0]  scale_mode_i = '0, us_mode_i = '0;
    logic        sink_hdmi_i = 1'b0;
    logic [7:0]  us_hborder_i = '0, us_vborder_i = '0;
    logic        done_o;
    logic [31:0] out_size_o;
    logic        active_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] held_size = '0;
    bit          held_act  = 0;

    always #4 clk = ~clk;

    scaler_size_calc u_scaler_size_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .src_w_i(src_w_i), .src_h_i(src_h_i), .src_ilace_i(src_ilace_i),
        .src_dbl_i(src_dbl_i), .nat_w_i(nat_w_i), .nat_h_i(nat_h_i),
        .nat_dbl_i(nat_dbl_i), .scale_mode_i(scale_mode_i), .us_mode_i(us_mode_i),
        .sink_hdmi_i(sink_hdmi_i), .us_hborder_i(us_hborder_i),
        .us_vborder_i(us_vborder_i), .done_o(done_o), .out_size_o(out_size_o),
        .active_o(active_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: expected width, height, flag and due edge.
    task automatic model(input int sw, sh, input bit sil, sdb, input int nw, nh,
                         input bit ndb, input int sm, um, input bit hdmi,
                         input int hb, vb,
                         output longint ow, oh, output bit act, output int lat);
        longint a, q;
        bit dbl;
        ow  = (sm == 0) ? sw : nw;
        oh  = (sm == 0) ? sh : nh;
        dbl = (sm == 0) ? sdb : ndb;
        if (dbl) oh = (oh * 2) & 16'hFFFF;
        lat = 2;
        if (um == 1 || (um == 2 && hdmi)) begin
            lat += QW + 4;
            a = (oh << FRAC) / ow;
            if (hb != 0) ow = ow - 2 * hb;
            else         ow = ow - (ow >> 4) - 32;
            ow &= 16'hFFFF;
            if (vb != 0) oh = (oh - 2 * vb) & 16'hFFFF;
            else         oh = ((ow * a + a / 2) >> FRAC) & 16'hFFFF;
        end
        if (sm == 2) begin
            if (sw < ow) ow = sw;
            if (sh < oh) oh = sh;
        end else if (sm == 3) begin
            lat += QW + 3;
            if (longint'(sw) * oh >= longint'(sh) * ow) begin
                q  = (longint'(sh) << FRAC) / sw;
                oh = ((ow * q + q / 2) >> FRAC) & 16'hFFFF;
            end else begin
                q  = (longint'(sw) << FRAC) / sh;
                ow = ((oh * q + q / 2) >> FRAC) & 16'hFFFF;
            end
        end
        act = (ow != sw) || (oh != sh) || sil || sdb;
    endtask

    task automatic run(input string req, input int sw, sh, input bit sil, sdb,
                       input int nw, nh, input bit ndb, input int sm, um,
                       input bit hdmi, input int hb, vb, input int poke);
        longint ow, oh;
        bit act;
        int lat;
        logic [31:0] exp_size;
        model(sw, sh, sil, sdb, nw, nh, ndb, sm, um, hdmi, hb, vb, ow, oh, act, lat);
        exp_size = {oh[15:0], ow[15:0]};
        @(negedge clk);
        src_w_i = 16'(sw); src_h_i = 16'(sh); src_ilace_i = sil; src_dbl_i = sdb;
        nat_w_i = 16'(nw); nat_h_i = 16'(nh); nat_dbl_i = ndb;
        scale_mode_i = 2'(sm); us_mode_i = 2'(um); sink_hdmi_i = hdmi;
        us_hborder_i = 8'(hb); us_vborder_i = 8'(vb);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R11", "done right after start", done_o, 0);
        for (int k = 1; k <= lat + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke > 0 && k == poke) begin
                start_i = 1'b1; src_w_i = 16'(sw + 7); scale_mode_i = 2'(sm ^ 1);
            end else if (poke > 0 && k == poke + 1) begin
                start_i = 1'b0; src_w_i = 16'(sw); scale_mode_i = 2'(sm);
            end
            check(done_o == (k == lat), (k == lat) ? req : "R11", "done timing",
                  done_o, (k == lat));
            if (k < lat) begin
                check(out_size_o == held_size && active_o == held_act, "R12",
                      "hold before result", out_size_o, held_size);
            end else begin
                check(out_size_o == exp_size, req, "packed size", out_size_o, exp_size);
                check(active_o == act, req, "active flag", active_o, act);
            end
        end
        held_size = exp_size;
        held_act  = act;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(done_o == 1'b0, "R13", "reset done", done_o, 0);
        check(out_size_o == '0, "R13", "reset size", out_size_o, 0);
        check(active_o == 1'b0, "R13", "reset active", active_o, 0);

        // R1 none mode takes the source size; R10 packing; no change -> inactive
        run("R1",  640, 480, 0, 0, 1920, 1080, 0, 0, 0, 0, 0, 0, 0);
        // R2 double-scan source doubles height
        run("R2",  320, 240, 0, 1, 1920, 1080, 0, 0, 0, 0, 0, 0, 0);
        // R2 native double-scan flag used when scaling
        run("R2",  640, 480, 0, 0, 800, 300, 1, 1, 0, 0, 0, 0, 0);
        // R8 full mode uses the native size untouched
        run("R8",  1280, 720, 0, 0, 1920, 1080, 0, 1, 0, 0, 0, 0, 0);
        // R6 center clamps each dimension
        run("R6",  1280, 720, 0, 0, 1024, 768, 0, 2, 0, 0, 0, 0, 0);
        run("R6",  640, 480, 0, 0, 1920, 1080, 0, 2, 0, 0, 0, 0, 0);
        // R7 wide source keeps width, narrow source keeps height
        run("R7",  1280, 720, 0, 0, 1280, 1024, 0, 3, 0, 0, 0, 0, 0);
        run("R7",  640, 480, 0, 0, 1920, 1080, 0, 3, 0, 0, 0, 0, 0);
        // R9 same size but interlaced
        run("R9",  1920, 1080, 1, 0, 1920, 1080, 0, 1, 0, 0, 0, 0, 0);
        // R4 R5 forced underscan with derived width and height
        run("R5",  1920, 1080, 0, 0, 800, 600, 0, 0, 1, 0, 0, 0, 0);
        // R4 R5 auto underscan on an HDMI sink with both borders
        run("R4",  1280, 1024, 0, 0, 1280, 1024, 0, 1, 2, 1, 16, 20, 0);
        // R4 border on width only, derived height
        run("R4",  1280, 720, 0, 0, 1366, 768, 0, 1, 1, 0, 24, 0, 0);
        // R3 auto without HDMI and the reserved code leave the size alone
        run("R3",  1280, 720, 0, 0, 1920, 1080, 0, 1, 2, 0, 30, 30, 0);
        run("R3",  1280, 720, 0, 0, 1920, 1080, 0, 1, 3, 1, 30, 30, 0);
        // R7 after underscan
        run("R7",  1280, 720, 0, 0, 1920, 1200, 0, 3, 1, 0, 0, 0, 0);
        // R12 start pulses mid-job with altered inputs are ignored
        run("R12", 1024, 768, 0, 0, 1920, 1080, 0, 3, 1, 0, 0, 0, 5);
        run("R12", 800, 600, 0, 0, 1280, 1024, 0, 2, 0, 0, 0, 0, 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule